// File: doc/BRIEF.md
# Byte-Wise Serial Flash Access Engine

This block gives software byte-at-a-time access to an external serial NOR flash. Software loads a small register file with the address, the byte to program, the read opcodes and the lane configuration. It then writes a command code. The engine selects the flash, runs the opcode, address, dummy and data phases, and deselects the flash. When it finishes it clears the command readback, which is the completion flag software polls.

Four commands exist: read one byte, program one byte, fetch the status byte, and store a status byte. Reads can run on one, two or four data lanes. The address can also go out on two or four lanes. The engine adds dummy clocks for any fast or multi-lane read. After each byte read or byte program the 32-bit address steps forward by one, so repeated commands walk through consecutive bytes. No command is accepted until an access key is written.

Top module: `pio_flash_ctrl`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, no lane is driven, and the command and read-data registers read 0.
- R2: A command written while the key register (offset 0xD) holds any value other than 0x30 is ignored. Chip select stays high and the command register reads 0.
- R3: Command 0x81 (offset 0x0), with lane mode 0 and the fast bit clear, sends opcode 0x03 on io0. It then sends address bits 23..0 MSB first on io0 and samples 8 data bits on io1. The byte is readable at offset 0x1 once the command register reads 0.
- R4: With bit 0 of the configuration register (offset 0xA) set, a read sends the opcode held at offset 0xB, followed by 8 dummy clocks after the address.
- R5: Lane mode (offset 0x9) bit 0 selects dual data. The read uses the offset 0xB opcode and 8 dummy clocks, and samples 2 bits per clock with io1 carrying the more significant bit.
- R6: Lane mode bit 2 selects quad data and takes priority over bit 0. The read uses the opcode at offset 0xC and 8 dummy clocks, and samples 4 bits per clock with io3 most significant.
- R7: Lane mode bit 1 sends the address on io1..io0, 2 bits per clock. Bit 3 sends it on io3..io0, 4 bits per clock and takes priority over bit 1. The most significant bits go on the highest lane.
- R8: Command 0x90 sends opcode 0x02, the 24-bit address, and then the byte at offset 0x2, all on io0.
- R9: After command 0x81 or 0x90 the 32-bit address (offsets 0x5 to 0x8, low byte first) increases by one, carrying across bytes. Status commands leave it unchanged.
- R10: Command 0x02 sends opcode 0x05 and stores the 8 bits sampled on io1 at offset 0x3.
- R11: Command 0x20 sends opcode 0x01 followed by the top N bits of the byte at offset 0x4, where N is the bit-count register at offset 0xE, capped at 8.
- R12: While a command runs, the command register reads back its code and further command writes are ignored. Codes other than the four listed are ignored.
- R13: The serial clock and lane enables are inactive while chip select is high. Each clock high phase lasts one cycle, and only io0 drives during opcode phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| spi_sck | output | 1 | Serial flash clock |
| spi_cs_n | output | 1 | Flash select, active low |
| spi_io_out | output | 4 | Lane output values |
| spi_io_oe | output | 4 | Lane output enables |
| spi_io_in | input | 4 | Lane input values |

## Verification
Results appear only after the command readback falls to zero. The read byte, status byte and stepped address are written on the same edge at which chip select rises. A single-lane byte read takes about 84 cycles from command acceptance: one load cycle per phase and two cycles per serial clock. The bench therefore never waits a fixed delay. It polls the command register on falling clock edges and reads the result registers only after the readback shows zero. The flash model samples lanes on the rising serial clock and changes its outputs on the falling one. The engine samples on the edge that raises the clock, one full cycle after the model's data settles.

// File: rtl/pio_flash_pkg.sv
package pio_flash_pkg;
    localparam int DW     = 8;
    localparam int ADDR_W = 32;
    localparam int SR_W   = 32;
    localparam int CNT_W  = 6;
    localparam int LANES  = 4;

    localparam logic [7:0] CMD_RD  = 8'h81;
    localparam logic [7:0] CMD_WR  = 8'h90;
    localparam logic [7:0] CMD_SRD = 8'h02;
    localparam logic [7:0] CMD_SWR = 8'h20;

    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;

    localparam logic [3:0] A_CMD   = 4'h0;
    localparam logic [3:0] A_RDATA = 4'h1;
    localparam logic [3:0] A_WDATA = 4'h2;
    localparam logic [3:0] A_STAT  = 4'h3;
    localparam logic [3:0] A_STWR  = 4'h4;
    localparam logic [3:0] A_ADR0  = 4'h5;
    localparam logic [3:0] A_ADR1  = 4'h6;
    localparam logic [3:0] A_ADR2  = 4'h7;
    localparam logic [3:0] A_ADR3  = 4'h8;
    localparam logic [3:0] A_LANE  = 4'h9;
    localparam logic [3:0] A_CFG   = 4'hA;
    localparam logic [3:0] A_OPSTD = 4'hB;
    localparam logic [3:0] A_OPQD  = 4'hC;
    localparam logic [3:0] A_KEY   = 4'hD;
    localparam logic [3:0] A_BITS  = 4'hE;

    typedef enum logic [2:0] {
        PH_IDLE, PH_OPC, PH_ADR, PH_DMY, PH_DAT, PH_END
    } phase_e;

    typedef struct packed {
        phase_e             ph;
        logic               launched;
        logic [DW-1:0]      cmd;
        logic [DW-1:0]      rdata;
        logic [DW-1:0]      wdata;
        logic [DW-1:0]      stat;
        logic [DW-1:0]      stwr;
        logic [DW-1:0]      lane;
        logic [DW-1:0]      cfg;
        logic [DW-1:0]      opc_std;
        logic [DW-1:0]      opc_quad;
        logic [DW-1:0]      key;
        logic [DW-1:0]      bits;
        logic [ADDR_W-1:0]  addr;
    } ctrl_t;

    function automatic logic [LANES-1:0] lane_mask(input logic [1:0] lg);
        case (lg)
            2'd2:    return 4'b1111;
            2'd1:    return 4'b0011;
            default: return 4'b0001;
        endcase
    endfunction
endpackage

// File: rtl/lane_mode_decode.sv
module lane_mode_decode
    import pio_flash_pkg::*;
(
    input  logic [DW-1:0] lane_mode,
    input  logic          fast_en,
    input  logic [DW-1:0] opc_std,
    input  logic [DW-1:0] opc_quad,
    output logic [DW-1:0] read_opc,
    output logic [1:0]    addr_lg,
    output logic [1:0]    data_lg,
    output logic          dummy_en
);
    logic dual_d, dual_a, quad_d, quad_a;

    always_comb begin
        dual_d   = lane_mode[0];
        dual_a   = lane_mode[1];
        quad_d   = lane_mode[2];
        quad_a   = lane_mode[3];
        data_lg  = quad_d ? 2'd2 : (dual_d ? 2'd1 : 2'd0);
        addr_lg  = quad_a ? 2'd2 : (dual_a ? 2'd1 : 2'd0);
        dummy_en = fast_en | dual_d | quad_d;
        if (quad_d)
            read_opc = opc_quad;
        else if (fast_en | dual_d)
            read_opc = opc_std;
        else
            read_opc = OP_READ;
    end
endmodule

// File: rtl/lane_shifter.sv
module lane_shifter
    import pio_flash_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SR_W-1:0]  tx,
    input  logic [1:0]       lg,
    input  logic [CNT_W-1:0] nclk,
    input  logic [LANES-1:0] oe_mask,
    input  logic [LANES-1:0] io_in,
    output logic             sck,
    output logic [LANES-1:0] io_out,
    output logic [LANES-1:0] io_oe,
    output logic [DW-1:0]    rx,
    output logic             done
);
    typedef struct packed {
        logic             active;
        logic             ph;
        logic [CNT_W-1:0] cnt;
        logic [SR_W-1:0]  sr;
        logic [DW-1:0]    rx;
        logic [1:0]       lg;
        logic [LANES-1:0] oe;
    } shf_t;

    shf_t q, d;

    always_comb begin
        d    = q;
        done = q.active && q.ph && (q.cnt == CNT_W'(1));
        if (start && nclk != '0) begin
            d.active = 1'b1;
            d.ph     = 1'b0;
            d.cnt    = nclk;
            d.sr     = tx;
            d.lg     = lg;
            d.oe     = oe_mask;
        end else if (q.active) begin
            if (!q.ph) begin
                d.ph = 1'b1;
                case (q.lg)
                    2'd2:    d.rx = {q.rx[DW-5:0], io_in};
                    2'd1:    d.rx = {q.rx[DW-3:0], io_in[1:0]};
                    default: d.rx = {q.rx[DW-2:0], io_in[1]};
                endcase
            end else begin
                d.ph  = 1'b0;
                d.sr  = q.sr << (1 << q.lg);
                d.cnt = q.cnt - CNT_W'(1);
                if (q.cnt == CNT_W'(1))
                    d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic used;
        assign used      = (i < (1 << q.lg));
        assign io_out[i] = (q.active && used) ? q.sr[SR_W - (1 << q.lg) + i] : 1'b0;
        assign io_oe[i]  = q.active & q.oe[i];
    end

    assign sck = q.active & q.ph;
    assign rx  = q.rx;
endmodule

// File: rtl/pio_flash_ctrl.sv
module pio_flash_ctrl
    import pio_flash_pkg::*;
#(
    parameter logic [7:0] KEY_VALUE  = 8'h30,
    parameter int         DUMMY_CLKS = 8,
    parameter int         ADDR_SENT  = 24
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [3:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             spi_sck,
    output logic             spi_cs_n,
    output logic [LANES-1:0] spi_io_out,
    output logic [LANES-1:0] spi_io_oe,
    input  logic [LANES-1:0] spi_io_in
);
    localparam int PAD_A = SR_W - ADDR_SENT;
    localparam int PAD_D = SR_W - DW;

    ctrl_t q, d;

    logic [DW-1:0]    read_opc, opc_sel;
    logic [1:0]       addr_lg, data_lg;
    logic             dummy_en;
    logic             sh_start, sh_done;
    logic [SR_W-1:0]  sh_tx;
    logic [1:0]       sh_lg;
    logic [CNT_W-1:0] sh_nclk, swr_bits;
    logic [LANES-1:0] sh_oe;
    logic [DW-1:0]    sh_rx;
    logic             is_rd, is_wr, is_srd, is_swr, busy, code_ok;
    logic             key_ok;
    logic [DW-1:0]    cmd_code;
    logic [ADDR_W-1:0] cur_addr;

    lane_mode_decode u_dec (
        .lane_mode (q.lane),
        .fast_en   (q.cfg[0]),
        .opc_std   (q.opc_std),
        .opc_quad  (q.opc_quad),
        .read_opc  (read_opc),
        .addr_lg   (addr_lg),
        .data_lg   (data_lg),
        .dummy_en  (dummy_en)
    );

    lane_shifter u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx      (sh_tx),
        .lg      (sh_lg),
        .nclk    (sh_nclk),
        .oe_mask (sh_oe),
        .io_in   (spi_io_in),
        .sck     (spi_sck),
        .io_out  (spi_io_out),
        .io_oe   (spi_io_oe),
        .rx      (sh_rx),
        .done    (sh_done)
    );

    assign is_rd    = (q.cmd == CMD_RD);
    assign is_wr    = (q.cmd == CMD_WR);
    assign is_srd   = (q.cmd == CMD_SRD);
    assign is_swr   = (q.cmd == CMD_SWR);
    assign busy     = (q.ph != PH_IDLE);
    assign key_ok   = (q.key == KEY_VALUE);
    assign cmd_code = q.cmd;
    assign cur_addr = q.addr;
    assign swr_bits = (q.bits > 8'd8) ? CNT_W'(8) : CNT_W'(q.bits);
    assign code_ok  = (reg_wdata == CMD_RD) || (reg_wdata == CMD_WR) ||
                      (reg_wdata == CMD_SRD) || (reg_wdata == CMD_SWR);

    // Phase parameters handed to the shifter
    always_comb begin
        if (is_rd)       opc_sel = read_opc;
        else if (is_wr)  opc_sel = OP_PROG;
        else if (is_srd) opc_sel = OP_RDSR;
        else             opc_sel = OP_WRSR;
        sh_tx   = '0;
        sh_lg   = 2'd0;
        sh_nclk = '0;
        sh_oe   = '0;
        case (q.ph)
            PH_OPC: begin
                sh_tx   = {opc_sel, {PAD_D{1'b0}}};
                sh_nclk = CNT_W'(DW);
                sh_oe   = 4'b0001;
            end
            PH_ADR: begin
                sh_tx   = {q.addr[ADDR_SENT-1:0], {PAD_A{1'b0}}};
                sh_lg   = addr_lg;
                sh_nclk = CNT_W'(ADDR_SENT >> addr_lg);
                sh_oe   = lane_mask(addr_lg);
            end
            PH_DMY: sh_nclk = CNT_W'(DUMMY_CLKS);
            PH_DAT: begin
                if (is_wr) begin
                    sh_tx   = {q.wdata, {PAD_D{1'b0}}};
                    sh_nclk = CNT_W'(DW);
                    sh_oe   = 4'b0001;
                end else if (is_swr) begin
                    sh_tx   = {q.stwr, {PAD_D{1'b0}}};
                    sh_nclk = swr_bits;
                    sh_oe   = 4'b0001;
                end else if (is_rd) begin
                    sh_lg   = data_lg;
                    sh_nclk = CNT_W'(DW >> data_lg);
                end else begin
                    sh_nclk = CNT_W'(DW);
                end
            end
            default: ;
        endcase
    end

    // Next-state computation
    always_comb begin
        d        = q;
        sh_start = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                A_CMD:   if (!busy && key_ok && code_ok) begin
                             d.cmd      = reg_wdata;
                             d.ph       = PH_OPC;
                             d.launched = 1'b0;
                         end
                A_WDATA: d.wdata       = reg_wdata;
                A_STWR:  d.stwr        = reg_wdata;
                A_ADR0:  d.addr[7:0]   = reg_wdata;
                A_ADR1:  d.addr[15:8]  = reg_wdata;
                A_ADR2:  d.addr[23:16] = reg_wdata;
                A_ADR3:  d.addr[31:24] = reg_wdata;
                A_LANE:  d.lane        = reg_wdata;
                A_CFG:   d.cfg         = reg_wdata;
                A_OPSTD: d.opc_std     = reg_wdata;
                A_OPQD:  d.opc_quad    = reg_wdata;
                A_KEY:   d.key         = reg_wdata;
                A_BITS:  d.bits        = reg_wdata;
                default: ;
            endcase
        end
        case (q.ph)
            PH_OPC, PH_ADR, PH_DMY, PH_DAT: begin
                if (!q.launched) begin
                    sh_start   = 1'b1;
                    d.launched = 1'b1;
                end else if (sh_done) begin
                    d.launched = 1'b0;
                    case (q.ph)
                        PH_OPC:  d.ph = (is_rd || is_wr) ? PH_ADR :
                                        ((is_swr && swr_bits == '0) ? PH_END : PH_DAT);
                        PH_ADR:  d.ph = (is_rd && dummy_en) ? PH_DMY : PH_DAT;
                        PH_DMY:  d.ph = PH_DAT;
                        default: d.ph = PH_END;
                    endcase
                end
            end
            PH_END: begin
                d.ph  = PH_IDLE;
                d.cmd = '0;
                if (is_rd)  d.rdata = sh_rx;
                if (is_srd) d.stat  = sh_rx;
                if (is_rd || is_wr) d.addr = q.addr + ADDR_W'(1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign spi_cs_n = !busy;

    always_comb begin
        case (reg_addr)
            A_CMD:   reg_rdata = busy ? q.cmd : '0;
            A_RDATA: reg_rdata = q.rdata;
            A_WDATA: reg_rdata = q.wdata;
            A_STAT:  reg_rdata = q.stat;
            A_STWR:  reg_rdata = q.stwr;
            A_ADR0:  reg_rdata = q.addr[7:0];
            A_ADR1:  reg_rdata = q.addr[15:8];
            A_ADR2:  reg_rdata = q.addr[23:16];
            A_ADR3:  reg_rdata = q.addr[31:24];
            A_LANE:  reg_rdata = q.lane;
            A_CFG:   reg_rdata = q.cfg;
            A_OPSTD: reg_rdata = q.opc_std;
            A_OPQD:  reg_rdata = q.opc_quad;
            A_KEY:   reg_rdata = q.key;
            A_BITS:  reg_rdata = q.bits;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pio_flash_checker.sv
module pio_flash_checker
    import pio_flash_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              spi_sck,
    input logic [LANES-1:0]  spi_io_oe,
    input logic              key_ok,
    input logic [DW-1:0]     cmd_code,
    input logic [ADDR_W-1:0] cur_addr
);
    p_quiet_bus_r13: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> (!spi_sck && spi_io_oe == '0));

    p_sck_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |=> !spi_sck);

    p_key_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> $past(key_ok));

    p_oe_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_io_oe == 4'b0000 || spi_io_oe == 4'b0001 ||
         spi_io_oe == 4'b0011 || spi_io_oe == 4'b1111));

    p_cmd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && !$past(spi_cs_n)) |-> $stable(cmd_code));

    p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(spi_cs_n) && ($past(cmd_code) == CMD_RD || $past(cmd_code) == CMD_WR))
        |-> (cur_addr == $past(cur_addr) + ADDR_W'(1)));
endmodule

bind pio_flash_ctrl pio_flash_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_cs_n  (spi_cs_n),
    .spi_sck   (spi_sck),
    .spi_io_oe (spi_io_oe),
    .key_ok    (key_ok),
    .cmd_code  (cmd_code),
    .cur_addr  (cur_addr)
);

// File: tb/pio_flash_ctrl_test.sv
module pio_flash_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       spi_sck, spi_cs_n;
    logic [3:0] spi_io_out, spi_io_oe;
    logic [3:0] spi_io_in = 4'h0;

    int n_checks = 0;
    int n_fail   = 0;
    int cs_falls = 0;

    // model-side view of the configuration, set by the bench
    logic [3:0] tb_lane = 4'h0;
    logic       tb_fast = 1'b0;
    logic [7:0] tb_bits = 8'd8;
    logic [7:0] mem [256];
    logic [7:0] flash_sr = 8'h00;
    logic [7:0] last_op = 8'h00;
    logic [23:0] last_addr = 24'h0;
    logic [7:0] last_sw = 8'h00;

    pio_flash_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe),
        .spi_io_in(spi_io_in)
    );

    always #10 clk = ~clk;

    always @(negedge spi_cs_n) cs_falls++;

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle(input string tag);
        logic [7:0] v;
        int k;
        for (k = 0; k < 3000; k++) begin
            reg_read(4'h0, v);
            if (v == 8'h00) break;
        end
        check(k < 3000, tag, 32'(k), 32'd3000);
    endtask

    task automatic run_cmd(input logic [7:0] code, input string tag);
        reg_write(4'h0, code);
        wait_idle(tag);
    endtask

    task automatic set_addr(input logic [31:0] a);
        reg_write(4'h5, a[7:0]);
        reg_write(4'h6, a[15:8]);
        reg_write(4'h7, a[23:16]);
        reg_write(4'h8, a[31:24]);
    endtask

    task automatic get_addr(output logic [31:0] a);
        logic [7:0] b;
        reg_read(4'h5, b); a[7:0]   = b;
        reg_read(4'h6, b); a[15:8]  = b;
        reg_read(4'h7, b); a[23:16] = b;
        reg_read(4'h8, b); a[31:24] = b;
    endtask

    // behavioural flash
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        forever begin
            logic [7:0] op, dat;
            logic [23:0] a;
            int aw, dw, nb;
            @(negedge spi_cs_n);
            op = 8'h00;
            for (int i = 0; i < 8; i++) begin
                @(posedge spi_sck); op = {op[6:0], spi_io_out[0]};
            end
            last_op = op;
            if (op == 8'h05) begin
                for (int i = 0; i < 8; i++) begin
                    @(negedge spi_sck); spi_io_in[1] = flash_sr[7-i];
                    @(posedge spi_sck);
                end
            end else if (op == 8'h01) begin
                nb = (tb_bits > 8) ? 8 : int'(tb_bits);
                dat = 8'h00;
                for (int i = 0; i < nb; i++) begin
                    @(posedge spi_sck); dat = {dat[6:0], spi_io_out[0]};
                end
                last_sw = dat;
            end else if (op == 8'h02) begin
                a = '0;
                for (int i = 0; i < 24; i++) begin
                    @(posedge spi_sck); a = {a[22:0], spi_io_out[0]};
                end
                dat = 8'h00;
                for (int i = 0; i < 8; i++) begin
                    @(posedge spi_sck); dat = {dat[6:0], spi_io_out[0]};
                end
                mem[a[7:0]] = dat;
                last_addr = a;
            end else begin
                aw = tb_lane[3] ? 4 : (tb_lane[1] ? 2 : 1);
                dw = tb_lane[2] ? 4 : (tb_lane[0] ? 2 : 1);
                a = '0;
                for (int i = 0; i < 24 / aw; i++) begin
                    @(posedge spi_sck);
                    if (aw == 4)      a = {a[19:0], spi_io_out};
                    else if (aw == 2) a = {a[21:0], spi_io_out[1:0]};
                    else              a = {a[22:0], spi_io_out[0]};
                end
                last_addr = a;
                if (tb_fast || tb_lane[0] || tb_lane[2])
                    for (int i = 0; i < 8; i++) @(posedge spi_sck);
                dat = mem[a[7:0]];
                for (int i = 0; i < 8 / dw; i++) begin
                    @(negedge spi_sck);
                    if (dw == 4)      spi_io_in = dat[7:4];
                    else if (dw == 2) spi_io_in[1:0] = dat[7:6];
                    else              spi_io_in[1] = dat[7];
                    dat = dat << dw;
                    @(posedge spi_sck);
                end
            end
        end
    end

    // lane, fast, address, expected opcode, expected byte
    localparam logic [44:0] VECS [0:5] = '{
        {4'h0, 1'b0, 24'h123410, 8'h03, 8'h4A},
        {4'h0, 1'b1, 24'h123433, 8'h0B, 8'h69},
        {4'h1, 1'b0, 24'h1234C7, 8'h0B, 8'h9D},
        {4'h4, 1'b0, 24'h12347E, 8'h6B, 8'h24},
        {4'h3, 1'b0, 24'h1234A5, 8'h0B, 8'hFF},
        {4'hC, 1'b0, 24'h123401, 8'h6B, 8'h5B}
    };

    initial begin
        logic [7:0] v;
        logic [31:0] a32;
        int falls0;

        // R1 reset state
        repeat (3) @(negedge clk);
        check(spi_cs_n === 1'b1 && spi_sck === 1'b0 && spi_io_oe === 4'h0, "R1 pins", {spi_cs_n, spi_sck, spi_io_oe}, 32'h20);
        rst_n = 1'b1;
        reg_read(4'h0, v); check(v == 8'h00, "R1 cmd", v, 8'h00);
        reg_read(4'h1, v); check(v == 8'h00, "R1 rdata", v, 8'h00);

        // R2 key gate
        falls0 = cs_falls;
        reg_write(4'h0, 8'h81);
        repeat (40) @(negedge clk);
        reg_read(4'h0, v);
        check(v == 8'h00 && cs_falls == falls0, "R2 no key", {v, 8'(cs_falls - falls0)}, 0);
        reg_write(4'hD, 8'h31);
        reg_write(4'h0, 8'h81);
        repeat (40) @(negedge clk);
        check(cs_falls == falls0, "R2 wrong key", cs_falls - falls0, 0);
        reg_write(4'hD, 8'h30);

        // R12 unknown code ignored
        reg_write(4'h0, 8'h55);
        repeat (20) @(negedge clk);
        reg_read(4'h0, v);
        check(v == 8'h00 && cs_falls == falls0, "R12 unknown code", v, 0);

        reg_write(4'hB, 8'h0B);
        reg_write(4'hC, 8'h6B);

        // table walk: R3 R4 R5 R6 R7 R9
        foreach (VECS[i]) begin
            logic [44:0] row;
            row = VECS[i];
            tb_lane = row[44:41]; tb_fast = row[40];
            reg_write(4'h9, {4'h0, row[44:41]});
            reg_write(4'hA, {7'h0, row[40]});
            set_addr({8'h00, row[39:16]});
            run_cmd(8'h81, "R3 read done");
            reg_read(4'h1, v);
            check(v == row[7:0], $sformatf("R3/R4/R5/R6 data row %0d", i), v, row[7:0]);
            check(last_op == row[15:8], $sformatf("R4/R5/R6 opcode row %0d", i), last_op, row[15:8]);
            check(last_addr == row[39:16], $sformatf("R7 address row %0d", i), last_addr, row[39:16]);
            get_addr(a32);
            check(a32 == {8'h00, row[39:16]} + 1, $sformatf("R9 step row %0d", i), a32, {8'h00, row[39:16]} + 1);
        end

        tb_lane = 4'h0; tb_fast = 1'b0;
        reg_write(4'h9, 8'h00);
        reg_write(4'hA, 8'h00);

        // R12 busy readback and command lockout
        set_addr(32'h0000_0020);
        falls0 = cs_falls;
        reg_write(4'h0, 8'h81);
        reg_read(4'h0, v);
        check(v == 8'h81, "R12 busy readback", v, 8'h81);
        reg_write(4'h0, 8'h02);
        reg_read(4'h0, v);
        check(v == 8'h81, "R12 lockout", v, 8'h81);
        wait_idle("R12 done");
        check(cs_falls == falls0 + 1 && last_op == 8'h03, "R12 single select", {cs_falls - falls0, 24'(last_op)}, 32'h01000003);

        // R8 byte program
        set_addr(32'h0000_00F0);
        reg_write(4'h2, 8'hC3);
        run_cmd(8'h90, "R8 done");
        check(mem[8'hF0] == 8'hC3 && last_op == 8'h02, "R8 program", {mem[8'hF0], last_op}, 16'hC302);
        check(last_addr == 24'h0000F0, "R8 address", last_addr, 24'h0000F0);
        get_addr(a32);
        check(a32 == 32'h0000_00F1, "R9 after write", a32, 32'h0000_00F1);
        set_addr(32'h0000_00F0);
        run_cmd(8'h81, "R3 readback done");
        reg_read(4'h1, v);
        check(v == 8'hC3, "R3 readback written", v, 8'hC3);

        // R9 carry
        set_addr(32'h00FF_FFFF);
        run_cmd(8'h81, "R9 carry done");
        reg_read(4'h1, v);
        check(v == 8'hA5, "R3 data at FF", v, 8'hA5);
        get_addr(a32);
        check(a32 == 32'h0100_0000, "R9 carry", a32, 32'h0100_0000);

        // R10 status read, R9 unchanged address
        flash_sr = 8'h9C;
        run_cmd(8'h02, "R10 done");
        reg_read(4'h3, v);
        check(v == 8'h9C && last_op == 8'h05, "R10 status", {v, last_op}, 16'h9C05);
        get_addr(a32);
        check(a32 == 32'h0100_0000, "R9 status no step", a32, 32'h0100_0000);

        // R11 status write
        tb_bits = 8'd8;
        reg_write(4'hE, 8'd8);
        reg_write(4'h4, 8'h47);
        run_cmd(8'h20, "R11 done");
        check(last_sw == 8'h47 && last_op == 8'h01, "R11 eight bits", {last_sw, last_op}, 16'h4701);
        tb_bits = 8'd4;
        reg_write(4'hE, 8'd4);
        reg_write(4'h4, 8'hA0);
        run_cmd(8'h20, "R11 four done");
        check(last_sw == 8'h0A, "R11 four bits", last_sw, 8'h0A);
        tb_bits = 8'd12;
        reg_write(4'hE, 8'd12);
        reg_write(4'h4, 8'h3C);
        run_cmd(8'h20, "R11 cap done");
        repeat (4) @(negedge clk);
        check(last_sw == 8'h3C && spi_cs_n === 1'b1, "R11 capped", {last_sw, 7'h0, spi_cs_n}, 16'h3C01);

        // R13 idle bus after all commands
        check(spi_sck === 1'b0 && spi_io_oe === 4'h0, "R13 idle bus", {spi_sck, spi_io_oe}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule